// File: doc/BRIEF.md
# I/O Module Verify-Error Bitmap

This block keeps a fault bitmap for a rack of I/O modules. On a capture strobe it records every slot's present status word as that slot's reference. From then on, any slot whose live status differs from its reference marks error bits in a 128-bit map. The map is organised as eight 16-bit words, and each bit stands for one group of 16 I/O points.

A slot does not mark bits according to its physical position. It marks the run of units that starts at its configured base unit number. The length of the run is its point count divided by 16 and rounded up. Marked bits are sticky: they stay set when the module returns to normal, and only a software clear removes them. Software reads the map one word at a time through a word select.

A two-state controller governs detection. In `ST_UNARMED`, the reset state, no reference exists and nothing is compared. The transition `capture` moves it to `ST_ARMED`, where every cycle without a capture strobe is a detection cycle. `ST_ARMED` has a single self-transition: a later capture only reloads the references and keeps the state.

Top module: `iov_verify_bitmap`

## Requirements
- R1: While reset is asserted, and after it is released, every bit of the map reads 0 and the controller is in `ST_UNARMED`.
- R2: While in `ST_UNARMED`, no status value sets any bit.
- R3: A cycle with `capture_i` high loads all references from the present status and sets no bit at the following edge, even if a status differs from its old reference. It also moves the controller to `ST_ARMED`.
- R4: In `ST_ARMED`, a cycle without capture in which a slot's status differs from its reference sets that slot's bits at the next rising edge. Those bits are units base through base+N-1, where N is the point count divided by 16 and rounded up.
- R5: Point counts that are not a multiple of 16 round up. For example, 40 points covers 3 units and 1 point covers 1 unit. A point count of 0 sets no bit.
- R6: A run that would pass unit 127 stops at unit 127 and does not wrap to unit 0.
- R7: Bit position comes from the slot's `slot_base_i` field, not from its slot index.
- R8: A set bit stays set after the slot's status matches its reference again, as long as no clear occurs.
- R9: A cycle with `clear_i` high and no detected mismatch leaves the whole map 0 after the next edge.
- R10: If clear and a detected mismatch happen in the same cycle, the mismatching slot's bits are set after the edge and all other bits are cleared.
- R11: `rd_data_o` combinationally shows word `rd_sel_i`, whose bit j is unit 16*`rd_sel_i`+j.
- R12: A later capture keeps the bits already set. After it, the newly captured status is the reference, so it no longer counts as a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| capture_i | input | 1 | Load all references from present status |
| clear_i | input | 1 | Software clear of the map |
| slot_status_i | input | NUM_SLOTS*STAT_W | Live status per slot, slot s at bits s*STAT_W |
| slot_base_i | input | NUM_SLOTS*7 | Configured first unit per slot, slot s at bits s*7 |
| slot_points_i | input | NUM_SLOTS*PTS_W | Point count per slot, slot s at bits s*PTS_W |
| rd_sel_i | input | 3 | Word select, 0 to 7 |
| rd_data_o | output | 16 | Selected 16-bit map word |

## Verification
Errors in the reference registers, the run decoder or the map register all appear at the read port one rising edge after the cycle that caused them. This holds whether the fault shows up as a missing run, a run shifted to the slot index, a run one unit too short or long, a wrapped run, or a bit lost without a clear. A wrong controller state shows the same way: bits appear before the first capture, or appear in a capture cycle. Because of this, the reference model compares all eight words after every edge, and a fault is caught in the first cycle it occurs. Directed cases cover the run boundaries, the clear-versus-mismatch collision and recapture. A randomised phase then mixes all inputs.

// File: rtl/iov_pkg.sv
package iov_pkg;
    localparam int UNIT_PTS   = 16;
    localparam int UNIT_SHIFT = $clog2(UNIT_PTS);
    localparam int WORD_W     = 16;
    localparam int NUM_WORDS  = 8;
    localparam int NUM_UNITS  = WORD_W * NUM_WORDS;
    localparam int UNIT_W     = $clog2(NUM_UNITS);
    localparam int SEL_W      = $clog2(NUM_WORDS);

    typedef enum logic [0:0] {
        ST_UNARMED = 1'b0,
        ST_ARMED   = 1'b1
    } iov_state_e;
endpackage

// File: rtl/iov_snapshot.sv
module iov_snapshot
    import iov_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int STAT_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap_i,
    input  logic [NUM_SLOTS*STAT_W-1:0]   status_i,
    output logic [NUM_SLOTS-1:0]          mism_o
);
    // One reference register per slot; compared combinationally.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [STAT_W-1:0] ref_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ref_q <= '0;
            end else if (cap_i) begin
                ref_q <= status_i[s*STAT_W +: STAT_W];
            end
        end

        assign mism_o[s] = (status_i[s*STAT_W +: STAT_W] != ref_q);
    end
endmodule

// File: rtl/iov_span_decode.sv
module iov_span_decode
    import iov_pkg::*;
#(
    parameter int PTS_W = 10
) (
    input  logic                 en_i,
    input  logic [UNIT_W-1:0]    base_i,
    input  logic [PTS_W-1:0]     pts_i,
    output logic [NUM_UNITS-1:0] mask_o
);
    localparam int CNT_W  = PTS_W + 1 - UNIT_SHIFT;
    localparam int SPAN_W = ((UNIT_W > CNT_W) ? UNIT_W : CNT_W) + 1;

    logic [PTS_W:0]    pts_up;
    logic [SPAN_W-1:0] first_u;
    logic [SPAN_W-1:0] stop_u;

    // Round up to whole units, then form a half-open unit range.
    assign pts_up  = {1'b0, pts_i} + (PTS_W+1)'(UNIT_PTS - 1);
    assign first_u = SPAN_W'(base_i);
    assign stop_u  = first_u + SPAN_W'(pts_up[PTS_W:UNIT_SHIFT]);

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        assign mask_o[u] = en_i && (SPAN_W'(u) >= first_u) && (SPAN_W'(u) < stop_u);
    end
endmodule

// File: rtl/iov_word_read.sv
module iov_word_read
    import iov_pkg::*;
(
    input  logic [NUM_UNITS-1:0] map_i,
    input  logic [SEL_W-1:0]     sel_i,
    output logic [WORD_W-1:0]    data_o
);
    logic [WORD_W-1:0] words [NUM_WORDS];

    for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
        assign words[k] = map_i[k*WORD_W +: WORD_W];
    end

    assign data_o = words[sel_i];
endmodule

// File: rtl/iov_verify_bitmap.sv
module iov_verify_bitmap
    import iov_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int STAT_W    = 8,
    parameter int PTS_W     = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          capture_i,
    input  logic                          clear_i,
    input  logic [NUM_SLOTS*STAT_W-1:0]   slot_status_i,
    input  logic [NUM_SLOTS*UNIT_W-1:0]   slot_base_i,
    input  logic [NUM_SLOTS*PTS_W-1:0]    slot_points_i,
    input  logic [SEL_W-1:0]              rd_sel_i,
    output logic [WORD_W-1:0]             rd_data_o
);
    iov_state_e            state_q;
    iov_state_e            state_d;
    logic                  detect_en;
    logic [NUM_SLOTS-1:0]  slot_mism;
    logic [NUM_UNITS-1:0]  slot_mask [NUM_SLOTS];
    logic [NUM_UNITS-1:0]  set_mask;
    logic [NUM_UNITS-1:0]  err_map_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and detection enable.
    always_comb begin
        state_d   = state_q;
        detect_en = 1'b0;
        unique case (state_q)
            ST_UNARMED: begin
                if (capture_i) begin
                    state_d = ST_ARMED;
                end
            end
            ST_ARMED: begin
                detect_en = !capture_i;
            end
            default: begin
                state_d = ST_UNARMED;
            end
        endcase
    end

    iov_snapshot #(
        .NUM_SLOTS (NUM_SLOTS),
        .STAT_W    (STAT_W)
    ) snap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_i    (capture_i),
        .status_i (slot_status_i),
        .mism_o   (slot_mism)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_span
        iov_span_decode #(
            .PTS_W (PTS_W)
        ) span_i (
            .en_i   (detect_en && slot_mism[s]),
            .base_i (slot_base_i[s*UNIT_W +: UNIT_W]),
            .pts_i  (slot_points_i[s*PTS_W +: PTS_W]),
            .mask_o (slot_mask[s])
        );
    end

    always_comb begin
        set_mask = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            set_mask = set_mask | slot_mask[s];
        end
    end

    // Sticky map: clear drops old bits, fresh mismatches always land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_map_q <= '0;
        end else if (clear_i) begin
            err_map_q <= set_mask;
        end else begin
            err_map_q <= err_map_q | set_mask;
        end
    end

    iov_word_read rd_i (
        .map_i  (err_map_q),
        .sel_i  (rd_sel_i),
        .data_o (rd_data_o)
    );
endmodule

// File: rtl/iov_verify_bitmap_chk.sv
module iov_verify_bitmap_chk
    import iov_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 capture_i,
    input logic                 clear_i,
    input iov_state_e           state_q,
    input logic [NUM_UNITS-1:0] err_map_q,
    input logic [NUM_SLOTS-1:0] mism
);
    AST_UNARMED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNARMED) |-> (err_map_q == '0)); // R2

    AST_CAPTURE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (state_q == ST_ARMED)); // R3

    AST_CAPTURE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> ((err_map_q & ~$past(err_map_q)) == '0)); // R3

    AST_SET_NEEDS_MISMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_ARMED) || capture_i || (mism == '0))
        |=> ((err_map_q & ~$past(err_map_q)) == '0)); // R4

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((err_map_q & $past(err_map_q)) == $past(err_map_q))); // R8

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && ((state_q != ST_ARMED) || capture_i || (mism == '0)))
        |=> (err_map_q == '0)); // R9

    AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> (state_q == ST_ARMED)); // R12
endmodule

bind iov_verify_bitmap iov_verify_bitmap_chk #(
    .NUM_SLOTS (NUM_SLOTS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture_i),
    .clear_i   (clear_i),
    .state_q   (state_q),
    .err_map_q (err_map_q),
    .mism      (slot_mism)
);

// File: tb/iov_verify_bitmap_tb_top.sv
`timescale 1ns/100ps
module iov_verify_bitmap_tb_top;
    localparam int NS = 8;
    localparam int SW = 8;
    localparam int PW = 10;
    localparam int BW = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              capture = 1'b0;
    logic              clear = 1'b0;
    logic [2:0]        rd_sel = '0;
    logic [15:0]       rd_data;
    logic [SW-1:0]     st  [NS];
    logic [SW-1:0]     st_saved [NS];
    logic [BW-1:0]     bs  [NS];
    logic [PW-1:0]     pt  [NS];
    logic [NS*SW-1:0]  st_flat;
    logic [NS*BW-1:0]  bs_flat;
    logic [NS*PW-1:0]  pt_flat;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural model state.
    bit    m_bits [128];
    int    m_ref  [NS];
    bit    m_armed = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int s = 0; s < NS; s++) begin
            st_flat[s*SW +: SW] = st[s];
            bs_flat[s*BW +: BW] = bs[s];
            pt_flat[s*PW +: PW] = pt[s];
        end
    end

    iov_verify_bitmap #(.NUM_SLOTS(NS), .STAT_W(SW), .PTS_W(PW)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .capture_i     (capture),
        .clear_i       (clear),
        .slot_status_i (st_flat),
        .slot_base_i   (bs_flat),
        .slot_points_i (pt_flat),
        .rd_sel_i      (rd_sel),
        .rd_data_o     (rd_data)
    );

    task automatic model_edge();
        bit nxt [128];
        if (!rst_n) begin
            foreach (m_bits[u]) m_bits[u] = 1'b0;
            foreach (m_ref[s]) m_ref[s] = 0;
            m_armed = 1'b0;
            return;
        end
        foreach (nxt[u]) nxt[u] = clear ? 1'b0 : m_bits[u];
        if (m_armed && !capture) begin
            for (int s = 0; s < NS; s++) begin
                if (int'(st[s]) != m_ref[s]) begin
                    int units = (int'(pt[s]) + 15) / 16;
                    for (int u = int'(bs[s]); u < int'(bs[s]) + units && u < 128; u++)
                        nxt[u] = 1'b1;
                end
            end
        end
        m_bits = nxt;
        if (capture) begin
            for (int s = 0; s < NS; s++) m_ref[s] = int'(st[s]);
            m_armed = 1'b1;
        end
    endtask

    task automatic compare_all();
        for (int w = 0; w < 8; w++) begin
            logic [15:0] exp_w;
            rd_sel = w[2:0];
            #0.1;
            for (int j = 0; j < 16; j++) exp_w[j] = m_bits[w*16 + j];
            checks++;
            if (rd_data !== exp_w) begin
                errors++;
                $display("FAIL %s (R11 word %0d): actual=%04h expected=%04h at %0t",
                         cur_req, w, rd_data, exp_w, $time);
            end
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        // Slot configuration: base unit and point count.
        bs[0] = 7'd0;   pt[0] = 10'd64;
        bs[1] = 7'd100; pt[1] = 10'd16;
        bs[2] = 7'd20;  pt[2] = 10'd40;
        bs[3] = 7'd50;  pt[3] = 10'd0;
        bs[4] = 7'd60;  pt[4] = 10'd17;
        bs[5] = 7'd125; pt[5] = 10'd128;
        bs[6] = 7'd64;  pt[6] = 10'd32;
        bs[7] = 7'd8;   pt[7] = 10'd1;
        for (int s = 0; s < NS; s++) st[s] = SW'(8'h10 + s);

        cur_req = "R1";
        @(negedge clk);
        ticks(3);
        rst_n = 1'b1;
        ticks(2);

        cur_req = "R2";
        st[0] ^= 8'h01; st[2] ^= 8'h40; st[5] ^= 8'h02;
        ticks(3);

        cur_req = "R3";
        capture = 1'b1;
        tick();
        capture = 1'b0;
        for (int s = 0; s < NS; s++) st_saved[s] = st[s];
        ticks(2);

        cur_req = "R4";
        st[0] ^= 8'h01;
        ticks(2);

        cur_req = "R5";
        st[2] ^= 8'h02; st[3] ^= 8'h04; st[4] ^= 8'h01; st[7] ^= 8'h01;
        ticks(2);

        cur_req = "R6";
        st[5] ^= 8'h01;
        ticks(2);

        cur_req = "R7";
        st[6] ^= 8'h01; st[1] ^= 8'h80;
        ticks(2);

        cur_req = "R8";
        for (int s = 0; s < NS; s++) st[s] = st_saved[s];
        ticks(3);

        cur_req = "R9";
        clear = 1'b1;
        tick();
        clear = 1'b0;
        ticks(2);

        cur_req = "R10";
        st[4] ^= 8'h08; st[6] ^= 8'h01;
        tick();
        st[6] = st_saved[6];
        clear = 1'b1;
        tick();
        clear = 1'b0;
        st[4] = st_saved[4];
        ticks(2);

        cur_req = "R3";
        st[2] ^= 8'h11;
        clear = 1'b1; capture = 1'b1;
        tick();
        clear = 1'b0; capture = 1'b0;
        ticks(2);

        cur_req = "R12";
        st[1] ^= 8'h01;
        tick();
        capture = 1'b1;
        tick();
        capture = 1'b0;
        ticks(3);
        clear = 1'b1;
        tick();
        clear = 1'b0;
        ticks(2);

        cur_req = "R4";
        for (int i = 0; i < 400; i++) begin
            int s = $urandom_range(NS - 1);
            if ($urandom_range(3) == 0) st[s] ^= SW'(1 << $urandom_range(SW - 1));
            if ($urandom_range(15) == 0) bs[s] = BW'($urandom_range(127));
            if ($urandom_range(15) == 0) pt[s] = PW'($urandom_range(300));
            clear   = ($urandom_range(11) == 0);
            capture = ($urandom_range(23) == 0);
            tick();
        end
        clear = 1'b0; capture = 1'b0;
        ticks(2);

        finish_run();
    end
endmodule